// File: doc/BRIEF.md
# Stereo Soft Mute and Attenuation Gain Stage

This block scales each frame of a stereo PCM stream by a gain that a mute request and an attenuate request control. Asserting the active-low mute input lowers the gain to silence along a raised-cosine curve. The curve is a table of 32 unsigned Q1.15 coefficients, each applied to 31 consecutive frames, followed by a zero state. Releasing mute walks the same table back up to unity. If mute is released partway down, or asserted again partway up, the walk turns around at the current coefficient and does not restart.

The active-low attenuate input applies a fixed quarter-amplitude cut of about 12 dB on top of the ramp gain. Both controls are sampled only in cycles that carry a frame (`in_valid` high). Changes between frames therefore never split a frame. Left and right share one gain state, so the dwell count advances once per stereo frame. A registered status output reports whether the ramp still has to move toward the level that was last requested.

Top module: `soft_mute_gain`

## Requirements
- R1: A frame presented with `in_valid` high appears on `out_left`/`out_right` with `out_valid` high exactly two clock cycles later. `out_valid` is low in every cycle that does not follow an accepted frame by two cycles.
- R2: The ramp position k runs from 0 to 32. For k below 32 the gain is round(32768·0.5·(1+cos(πk/32)))/32768, and k = 32 gives a gain of exactly zero. After reset k = 0, which is unity gain.
- R3: While frames arrive with `mute_n` low, k rises by one after the same k has been used for 31 frames. Starting from full level, the first frame that leaves `ramp_busy` low is the 992nd, and from then on every output is zero.
- R4: While frames arrive with `mute_n` high, k falls by one after 31 frames at the same k. From silence, full level returns after 992 frames, using the coefficients in reverse order.
- R5: When the sampled mute level differs from the one sampled at the previous frame, k is kept and its 31-frame count restarts, with the reversing frame counting as the first. Reversal after 165 muting frames from full level takes 155 frames to reach full level again.
- R6: The output is floor((x·c + 2^(s−1)) / 2^s), saturated to the sample width. Here x is the signed input, c is the coefficient, and s is 15, or 17 when attenuating. Rounding happens once per output.
- R7: With `atten_n` low at a frame, that frame is scaled by an extra 1/4. With `atten_n` high and k = 0, the output equals the input bit for bit.
- R8: `mute_n` and `atten_n` are sampled only in cycles where `in_valid` is high. Values they take in other cycles have no effect on any output.
- R9: After each frame, `ramp_busy` is high when the mute level sampled at that frame is low and k ≠ 32, or when that level is high and k ≠ 0. Otherwise it is low. It changes only on frames.
- R10: A synchronous reset clears `out_valid`, `out_left`, `out_right` and `ramp_busy` to zero and returns the ramp to k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stereo frame is present this cycle |
| in_left | input | SAMPLE_W | Left input sample, two's complement |
| in_right | input | SAMPLE_W | Right input sample, two's complement |
| mute_n | input | 1 | Mute request, active low, sampled per frame |
| atten_n | input | 1 | Quarter-amplitude cut request, active low, sampled per frame |
| out_valid | output | 1 | Output frame valid |
| out_left | output | SAMPLE_W | Left scaled sample |
| out_right | output | SAMPLE_W | Right scaled sample |
| ramp_busy | output | 1 | Ramp has not yet reached the requested endpoint |

## Verification
The hardest case to reach from the ports is a turnaround in the middle of a dwell, at a coefficient index other than the endpoints. The index and the dwell count are never visible directly. The stimulus holds mute low for exactly 165 frames, which leaves the ramp at index 5 with ten frames of dwell used. It then releases mute and counts frames until the busy flag drops. Random runs then toggle mute rarely, so that further turnarounds land at arbitrary points. Between frames the bench drives both control inputs to the opposite level, and it compares every output sample against a model computed from the cosine formula.

// File: rtl/smute_pkg.sv
package smute_pkg;
  localparam int STEPS     = 32;
  localparam int IDX_W     = 6;
  localparam int COEF_W    = 16;
  localparam int FRAC_W    = 15;
  localparam int ATT_SHIFT = 2;
  localparam logic [IDX_W-1:0]  IDX_SILENT = IDX_W'(STEPS);
  localparam logic [COEF_W-1:0] COEF_UNITY = COEF_W'(1 << FRAC_W);

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [COEF_W-1:0] coef_t;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_e;
endpackage

// File: rtl/smute_coef_rom.sv
module smute_coef_rom
  import smute_pkg::*;
(
  input  logic  clk,
  input  logic  rd_en,
  input  idx_t  addr,
  output coef_t data
);
  // raised-cosine gain table, Q1.15, index STEPS is the silent state
  function automatic coef_t lookup(idx_t a);
    coef_t v;
    case (a)
      6'd0:  v = 16'd32768;
      6'd1:  v = 16'd32689;
      6'd2:  v = 16'd32453;
      6'd3:  v = 16'd32063;
      6'd4:  v = 16'd31521;
      6'd5:  v = 16'd30833;
      6'd6:  v = 16'd30007;
      6'd7:  v = 16'd29049;
      6'd8:  v = 16'd27969;
      6'd9:  v = 16'd26778;
      6'd10: v = 16'd25486;
      6'd11: v = 16'd24107;
      6'd12: v = 16'd22654;
      6'd13: v = 16'd21140;
      6'd14: v = 16'd19580;
      6'd15: v = 16'd17990;
      6'd16: v = 16'd16384;
      6'd17: v = 16'd14778;
      6'd18: v = 16'd13188;
      6'd19: v = 16'd11628;
      6'd20: v = 16'd10114;
      6'd21: v = 16'd8661;
      6'd22: v = 16'd7282;
      6'd23: v = 16'd5990;
      6'd24: v = 16'd4799;
      6'd25: v = 16'd3719;
      6'd26: v = 16'd2761;
      6'd27: v = 16'd1935;
      6'd28: v = 16'd1247;
      6'd29: v = 16'd705;
      6'd30: v = 16'd315;
      6'd31: v = 16'd79;
      default: v = '0;
    endcase
    return v;
  endfunction

  coef_t rom_q;

  always_ff @(posedge clk) begin
    if (rd_en) rom_q <= lookup(addr);
  end

  assign data = rom_q;
endmodule

// File: rtl/smute_ramp_ctrl.sv
module smute_ramp_ctrl
  import smute_pkg::*;
#(
  parameter int HOLD_FRAMES = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic mute_req,
  output idx_t idx,
  output logic busy
);
  localparam int DW_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(HOLD_FRAMES - 1);

  idx_t            idx_q, idx_d;
  logic [DW_W-1:0] dwell_q, dwell_d, start;
  ramp_dir_e       dir_q, dir_d;
  logic            busy_q, busy_d, at_end;

  always_comb begin
    idx_d   = idx_q;
    dwell_d = dwell_q;
    dir_d   = dir_q;
    busy_d  = busy_q;
    start   = dwell_q;
    at_end  = 1'b0;
    if (adv) begin
      dir_d  = mute_req ? DIR_DOWN : DIR_UP;
      start  = (dir_d != dir_q) ? '0 : dwell_q;
      at_end = mute_req ? (idx_q == IDX_SILENT) : (idx_q == '0);
      if (at_end) begin
        dwell_d = '0;
      end else if (start == DW_LAST) begin
        dwell_d = '0;
        idx_d   = mute_req ? idx_q + idx_t'(1) : idx_q - idx_t'(1);
      end else begin
        dwell_d = start + DW_W'(1);
      end
      busy_d = mute_req ? (idx_d != IDX_SILENT) : (idx_d != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      dwell_q <= '0;
      dir_q   <= DIR_UP;
      busy_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      dwell_q <= dwell_d;
      dir_q   <= dir_d;
      busy_q  <= busy_d;
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_SILENT) else $error("ramp index out of range"); // R2
  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
    dwell_q <= DW_LAST) else $error("dwell count out of range"); // R3
  AST_MUTE_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
    (adv && mute_req) |=> (idx_q >= $past(idx_q))) else $error("gain rose while muting"); // R3
  AST_RELEASE_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
    (adv && !mute_req) |=> (idx_q <= $past(idx_q))) else $error("gain fell while released"); // R4
  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(idx_q) && $stable(busy_q))) else $error("state moved without a frame"); // R8
endmodule

// File: rtl/smute_gain_mul.sv
module smute_gain_mul
  import smute_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  coef_t                      coef,
  input  logic                       att,
  output logic signed [SAMPLE_W-1:0] res
);
  localparam int PW       = SAMPLE_W + COEF_W + 1;
  localparam int SH_UNITY = FRAC_W;
  localparam int SH_ATT   = FRAC_W + ATT_SHIFT;
  localparam logic signed [PW-1:0] RND_UNITY = PW'(64'sd1 <<< (SH_UNITY - 1));
  localparam logic signed [PW-1:0] RND_ATT   = PW'(64'sd1 <<< (SH_ATT - 1));
  localparam logic signed [PW-1:0] SAT_HI =
    $signed({{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
  localparam logic signed [PW-1:0] SAT_LO =
    $signed({{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});

  logic signed [PW-1:0]       smp_x, coef_x, prod, biased, scaled;
  logic signed [SAMPLE_W-1:0] res_d;
  logic [PW-1:0]              mag_in, mag_out;

  assign smp_x  = PW'(smp);
  assign coef_x = $signed({{(PW-COEF_W){1'b0}}, coef});
  assign prod   = smp_x * coef_x;
  assign biased = prod + (att ? RND_ATT : RND_UNITY);
  assign scaled = att ? (biased >>> SH_ATT) : (biased >>> SH_UNITY);

  always_comb begin
    if (scaled > SAT_HI)      res_d = SAT_HI[SAMPLE_W-1:0];
    else if (scaled < SAT_LO) res_d = SAT_LO[SAMPLE_W-1:0];
    else                      res_d = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     res <= '0;
    else if (en) res <= res_d;
  end

  assign mag_in  = smp_x[PW-1]  ? -smp_x  : smp_x;
  assign mag_out = scaled[PW-1] ? -scaled : scaled;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    en |-> (mag_out <= mag_in)) else $error("scaled sample exceeds input"); // R6
endmodule

// File: rtl/soft_mute_gain.sv
module soft_mute_gain
  import smute_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int HOLD_FRAMES = 31
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic                       mute_n,
  input  logic                       atten_n,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       ramp_busy
);
  localparam int N_CH = 2;

  idx_t  cur_idx;
  coef_t coef1;
  logic  v1, att1;
  logic signed [SAMPLE_W-1:0] smp_in [N_CH];
  logic signed [SAMPLE_W-1:0] smp1   [N_CH];
  logic signed [SAMPLE_W-1:0] smp_out[N_CH];
  logic signed [SAMPLE_W-1:0] s1_left;

  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  smute_ramp_ctrl #(.HOLD_FRAMES(HOLD_FRAMES)) ramp_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (in_valid),
    .mute_req (~mute_n),
    .idx      (cur_idx),
    .busy     (ramp_busy)
  );

  smute_coef_rom rom_i (
    .clk   (clk),
    .rd_en (in_valid),
    .addr  (cur_idx),
    .data  (coef1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      att1      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) att1 <= ~atten_n;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           smp1[ch] <= '0;
      else if (in_valid) smp1[ch] <= smp_in[ch];
    end

    smute_gain_mul #(.SAMPLE_W(SAMPLE_W)) mul_i (
      .clk  (clk),
      .rst  (rst),
      .en   (v1),
      .smp  (smp1[ch]),
      .coef (coef1),
      .att  (att1),
      .res  (smp_out[ch])
    );
  end

  assign out_left  = smp_out[0];
  assign out_right = smp_out[1];
  assign s1_left   = smp1[0];

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    v1 |=> out_valid) else $error("frame lost in pipeline"); // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> !out_valid) else $error("output valid without frame"); // R1
  AST_SILENT_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (v1 && coef1 == '0) |=> (out_left == '0 && out_right == '0)) else $error("silent gain leaked"); // R2
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
    (v1 && coef1 == COEF_UNITY && !att1) |=> (out_left == $past(s1_left))) else $error("unity gain altered sample"); // R7
endmodule

// File: tb/soft_mute_gain_tb_top.sv
module soft_mute_gain_tb_top;
  localparam int W = 24;
  localparam int HOLD = 31;
  localparam int STEPS = 32;
  localparam int WD_CYCLES = 190000;
  localparam longint MAXV = (longint'(1) <<< (W - 1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (W - 1));

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, mute_n, atten_n, out_valid, ramp_busy;
  logic signed [W-1:0] in_left, in_right, out_left, out_right;

  int n_checks = 0;
  int n_fail = 0;
  int m_idx = 0;
  int m_dwell = 0;
  bit m_down = 1'b0;

  soft_mute_gain #(.SAMPLE_W(W), .HOLD_FRAMES(HOLD)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .mute_n(mute_n), .atten_n(atten_n), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .ramp_busy(ramp_busy)
  );

  function automatic longint coef_of(int k);
    real v;
    if (k >= STEPS) return 0;
    v = 16384.0 * (1.0 + $cos(3.14159265358979324 * real'(k) / 32.0));
    return longint'($rtoi(v + 0.5));
  endfunction

  function automatic longint scale(longint x, longint g, bit att);
    int sh;
    longint q;
    sh = att ? 17 : 15;
    q = (x * g + (longint'(1) <<< (sh - 1))) >>> sh;
    if (q > MAXV) q = MAXV;
    if (q < MINV) q = MINV;
    return q;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit dn);
    int start;
    bit at_end;
    start = (dn != m_down) ? 0 : m_dwell;
    at_end = dn ? (m_idx == STEPS) : (m_idx == 0);
    if (at_end) m_dwell = 0;
    else if (start == HOLD - 1) begin
      m_dwell = 0;
      m_idx = dn ? m_idx + 1 : m_idx - 1;
    end else m_dwell = start + 1;
    m_down = dn;
  endtask

  task automatic frame(logic signed [W-1:0] l, logic signed [W-1:0] r,
                       bit mute, bit att, int gap, string tag);
    longint g;
    bit busy_exp;
    @(negedge clk);
    in_left = l; in_right = r; mute_n = ~mute; atten_n = ~att; in_valid = 1'b1;
    g = coef_of(m_idx);
    model_step(mute);
    busy_exp = mute ? (m_idx != STEPS) : (m_idx != 0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "ramp_busy", longint'(ramp_busy), longint'(busy_exp));
    // R8: controls and data flip while no frame is present
    mute_n = mute; atten_n = att; in_left = ~l; in_right = ~r;
    @(negedge clk);
    check("R1", "out_valid", longint'(out_valid), 1);
    check(tag, "out_left", longint'(out_left), scale(longint'(l), g, att));
    check(tag, "out_right", longint'(out_right), scale(longint'(r), g, att));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R8", "out_valid between frames", longint'(out_valid), 0);
      check("R8", "ramp_busy between frames", longint'(ramp_busy), longint'(busy_exp));
    end
  endtask

  function automatic logic signed [W-1:0] rnd_smp();
    return W'($urandom());
  endfunction

  task automatic run_until_idle(bit mute, string tag, output int n);
    n = 0;
    do begin
      frame(rnd_smp(), rnd_smp(), mute, 1'($urandom_range(0, 1)), $urandom_range(0, 2), tag);
      n++;
    end while (ramp_busy && n < 2000);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    bit mute_lvl;
    void'($urandom(32'd7321));
    rst = 1'b1; in_valid = 1'b0; mute_n = 1'b1; atten_n = 1'b1;
    in_left = '0; in_right = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", "out_valid", longint'(out_valid), 0);
    check("R10", "out_left", longint'(out_left), 0);
    check("R10", "out_right", longint'(out_right), 0);
    check("R10", "ramp_busy", longint'(ramp_busy), 0);

    // R7 / R6 full level, directed extremes then random
    frame(W'(MAXV), W'(MINV), 1'b0, 1'b0, 1, "R7");
    frame(W'(MAXV), W'(MINV), 1'b0, 1'b1, 1, "R7");
    frame(-24'sd1, 24'sd2, 1'b0, 1'b1, 1, "R6");
    frame(24'sd1, -24'sd2, 1'b0, 1'b1, 1, "R6");
    frame(24'sd3, -24'sd3, 1'b0, 1'b0, 0, "R7");
    for (int i = 0; i < 20; i++)
      frame(rnd_smp(), rnd_smp(), 1'b0, 1'($urandom_range(0, 1)), $urandom_range(0, 2), "R7");

    // R3 mute down to silence
    run_until_idle(1'b1, "R2", n);
    check("R3", "frames to silence", n, 992);
    for (int i = 0; i < 10; i++)
      frame(rnd_smp(), rnd_smp(), 1'b1, 1'($urandom_range(0, 1)), 1, "R3");
    check("R3", "out_left at silence", longint'(out_left), 0);

    // R4 release back to full
    run_until_idle(1'b0, "R4", n);
    check("R4", "frames to full level", n, 992);

    // R5 reversal mid-dwell at index 5
    for (int i = 0; i < 165; i++)
      frame(rnd_smp(), rnd_smp(), 1'b1, 1'($urandom_range(0, 1)), $urandom_range(0, 1), "R5");
    run_until_idle(1'b0, "R5", n);
    check("R5", "frames after reversal", n, 155);

    // R6 random traffic with rare mute toggles
    mute_lvl = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) mute_lvl = ~mute_lvl;
      frame(rnd_smp(), rnd_smp(), mute_lvl, 1'($urandom_range(0, 1)), $urandom_range(0, 2), "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule